// File: doc/BRIEF.md
# Two-Wire Timestamp Capture Unit

This block measures execution time on a target processor that has no timer, no spare memory and no link to a host. The target software marks each point of interest by changing two general-purpose pins. The block brings both pins into its own fast clock domain and decodes start, capture and stop events from them. It keeps the timestamps in an on-chip FIFO, where a reader collects them after the run.

The block is armed first, with both lines resting high and a stop limit already on its input. The first falling edge on either line starts the run. From that point a cycle counter advances once per clock. After that, each measurement point is one line falling while the other rises. Every such falling edge pushes the counter value into the FIFO. The run ends once both lines have stayed low for the programmed number of cycles plus one. The unit then reports done, freezes the counter and keeps the FIFO readable.

Both pin inputs pass through synchronisers of the same length. The synchroniser delay is therefore identical for every event, and the difference between two edges, counted in cycles, is preserved exactly in the timestamps.

Top module: `pin_stamp_unit`

## Requirements
- R1: After reset, `fifoEmpty` is 1 and `runBusy`, `runDone` and `fifoOverflow` are 0.
- R2: A one-cycle pulse on `armIn` does all of the following. It empties the FIFO, clears `runDone` and `fifoOverflow`, raises `runBusy` and latches `stopLimit`. While the unit is armed and both lines stay high, nothing is written. `runBusy` and `runDone` are never 1 at the same time.
- R3: The first falling edge on either line after arming starts the run. This start edge writes no timestamp.
- R4: A falling edge on one line while the other line is high is a capture. The unit writes the counter value into the FIFO. The first timestamp equals the number of clock cycles between the start edge and this capture edge at the pins.
- R5: The difference between two consecutive timestamps equals the number of clock cycles between their capture edges at the pins.
- R6: A falling edge that leaves both lines low writes nothing. If a line rises again before the stop limit expires, the run continues, and later timestamps still follow R4 and R5.
- R7: Once both lines have been low together for `stopLimit`+1 consecutive synchronised cycles, the run stops: `runBusy` falls and `runDone` rises. A shorter both-low period does not stop the run, and that includes a limit of 0.
- R8: After a stop, the counter is frozen, and pin activity writes nothing until the next arm.
- R9: The FIFO holds DEPTH timestamps. A capture that arrives while the FIFO is full is dropped and sets `fifoOverflow`. The first DEPTH timestamps are kept in order.
- R10: `fifoOverflow` stays set through the rest of the run and after the stop. Only the next arm pulse clears it.
- R11: `rdData` always shows the oldest entry. A cycle with `rdEn` high and `fifoEmpty` low removes that entry. `rdEn` while the FIFO is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock (200 MHz) |
| rstN | input | 1 | Active-low asynchronous reset |
| armIn | input | 1 | One-cycle arm command; clears the FIFO and flags |
| stopLimit | input | LIMIT_W | Both-low cycle limit, latched on arm |
| lineA | input | 1 | First target pin, asynchronous, idle high |
| lineB | input | 1 | Second target pin, asynchronous, idle high |
| rdEn | input | 1 | Pop the oldest timestamp |
| rdData | output | CNT_W | Oldest timestamp in the FIFO |
| fifoEmpty | output | 1 | FIFO holds no timestamp |
| fifoOverflow | output | 1 | Sticky: a capture was dropped |
| runBusy | output | 1 | Armed or running |
| runDone | output | 1 | Run has stopped |

## Verification
The bench builds the unit with DEPTH 8 and keeps the 32-bit counter and the 16-bit limit. The small FIFO lets a run overflow after a few captures, so the dropping and sticky-flag behaviour is tested alongside ordinary runs. The stop limits are drawn at random between 0 and 15. This covers the zero-limit boundary, and it also tests short both-low dips that must not end a run. Expected timestamps come from the cycle numbers at which the bench itself drives the pin edges.

// File: rtl/stamp_pkg.sv
package stamp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } runState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // arm: empty FIFO, zero counter, clear overflow
    logic start;    // run begins: counter loads 1
    logic run;      // counter advances
    logic capture;  // push counter value
  } stampStrobe_t;

endpackage

// File: rtl/stamp_ctrl.sv
module stamp_ctrl
  import stamp_pkg::*;
#(
  parameter int LIMIT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armIn,
  input  logic [LIMIT_W-1:0] stopLimit,
  input  logic               lineA,
  input  logic               lineB,
  output stampStrobe_t       strb,
  output logic               runBusy,
  output logic               runDone
);

  logic [1:0] pinRaw;
  logic [1:0] pinNow;
  logic [1:0] pinPrev;
  logic [1:0] pinFall;

  assign pinRaw = {lineB, lineA};

  // equal-length synchronisers, reset to the idle-high level
  for (genvar g = 0; g < 2; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg <= '1;
      else       shReg <= {shReg[SYNC_STAGES-2:0], pinRaw[g]};
    end
    assign pinNow[g] = shReg[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pinPrev <= 2'b11;
    else       pinPrev <= pinNow;
  end

  assign pinFall = pinPrev & ~pinNow;

  runState_t          state;
  logic [LIMIT_W-1:0] limitQ;
  logic [LIMIT_W-1:0] lowCnt;
  logic               bothLow;
  logic               startEv;
  logic               capEv;
  logic               stopEv;

  assign bothLow = ~|pinNow;
  assign startEv = (state == ST_ARMED) && (|pinFall);
  assign capEv   = (state == ST_RUN) &&
                   ((pinFall[0] && pinNow[1]) || (pinFall[1] && pinNow[0]));
  assign stopEv  = (state == ST_RUN) && bothLow && (lowCnt == limitQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      limitQ <= '0;
      lowCnt <= '0;
    end else begin
      if (armIn) limitQ <= stopLimit;
      if (armIn || state != ST_RUN || !bothLow) lowCnt <= '0;
      else                                      lowCnt <= lowCnt + 1'b1;
      if (armIn)        state <= ST_ARMED;
      else if (startEv) state <= ST_RUN;
      else if (stopEv)  state <= ST_DONE;
    end
  end

  always_comb begin
    strb.clear   = armIn;
    strb.start   = startEv && !armIn;
    strb.run     = (state == ST_RUN) && !armIn;
    strb.capture = capEv && !armIn;
  end

  assign runBusy = (state == ST_ARMED) || (state == ST_RUN);
  assign runDone = (state == ST_DONE);

  // R3: a run is entered only from the armed state
  p_start_from_armed_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && $past(state) != ST_RUN) |-> $past(state) == ST_ARMED);

  // R7: no stop while either line is high
  p_no_stop_line_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !bothLow && !armIn) |=> state == ST_RUN);

  // R8: done holds until the next arm
  p_done_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE && !armIn) |=> state == ST_DONE);

  // R6: a capture never coincides with both lines low
  p_no_capture_both_low_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |-> !bothLow);

endmodule

// File: rtl/stamp_datapath.sv
module stamp_datapath
  import stamp_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  stampStrobe_t     strb,
  input  logic             rdEn,
  output logic [CNT_W-1:0] rdData,
  output logic             fifoEmpty,
  output logic             fifoOverflow
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

  logic [CNT_W-1:0] timeBase;
  logic [CNT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr;
  logic [AW-1:0]    rdPtr;
  logic [AW:0]      fillCnt;
  logic             full;
  logic             wrOk;
  logic             rdOk;

  assign full      = (fillCnt == DEPTH_V);
  assign fifoEmpty = (fillCnt == '0);
  assign wrOk      = strb.capture && !full;
  assign rdOk      = rdEn && !fifoEmpty && !strb.clear;
  assign rdData    = mem[rdPtr];

  // time base: zero on arm, 1 in the cycle after start, frozen otherwise
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           timeBase <= '0;
    else if (strb.clear) timeBase <= '0;
    else if (strb.start) timeBase <= CNT_W'(1);
    else if (strb.run)   timeBase <= timeBase + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= timeBase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fillCnt      <= '0;
      fifoOverflow <= 1'b0;
    end else if (strb.clear) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fillCnt      <= '0;
      fifoOverflow <= 1'b0;
    end else begin
      if (wrOk) wrPtr <= wrPtr + 1'b1;
      if (rdOk) rdPtr <= rdPtr + 1'b1;
      case ({wrOk, rdOk})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
      if (strb.capture && full) fifoOverflow <= 1'b1;
    end
  end

  // R9: fill level never exceeds the depth
  p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    fillCnt <= DEPTH_V);

  // R10: overflow is sticky until arm
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    (fifoOverflow && !strb.clear) |=> fifoOverflow);

  // R8: counter frozen when neither running nor starting nor clearing
  p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.run && !strb.start && !strb.clear) |=> $stable(timeBase));

  // R11: reading an empty FIFO leaves it empty
  p_empty_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEmpty && rdEn && !strb.capture) |=> fifoEmpty);

endmodule

// File: rtl/pin_stamp_unit.sv
module pin_stamp_unit
  import stamp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int DEPTH       = 128,
  parameter int LIMIT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               armIn,
  input  logic [LIMIT_W-1:0] stopLimit,
  input  logic               lineA,
  input  logic               lineB,
  input  logic               rdEn,
  output logic [CNT_W-1:0]   rdData,
  output logic               fifoEmpty,
  output logic               fifoOverflow,
  output logic               runBusy,
  output logic               runDone
);

  stampStrobe_t strb;

  stamp_ctrl #(
    .LIMIT_W    (LIMIT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .armIn    (armIn),
    .stopLimit(stopLimit),
    .lineA    (lineA),
    .lineB    (lineB),
    .strb     (strb),
    .runBusy  (runBusy),
    .runDone  (runDone)
  );

  stamp_datapath #(
    .CNT_W(CNT_W),
    .DEPTH(DEPTH)
  ) i_data (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .rdEn        (rdEn),
    .rdData      (rdData),
    .fifoEmpty   (fifoEmpty),
    .fifoOverflow(fifoOverflow)
  );

  // R2: busy and done are exclusive
  p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(runBusy && runDone));

endmodule

// File: tb/test_pin_stamp_unit.sv
module test_pin_stamp_unit;

  localparam int CNT_W   = 32;
  localparam int DEPTH   = 8;
  localparam int LIMIT_W = 16;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               armIn = 1'b0;
  logic [LIMIT_W-1:0] stopLimit = '0;
  logic               lineA = 1'b1;
  logic               lineB = 1'b1;
  logic               rdEn = 1'b0;
  logic [CNT_W-1:0]   rdData;
  logic               fifoEmpty;
  logic               fifoOverflow;
  logic               runBusy;
  logic               runDone;

  pin_stamp_unit #(.CNT_W(CNT_W), .DEPTH(DEPTH), .LIMIT_W(LIMIT_W)) i_pin_stamp_unit (
    .clk(clk), .rstN(rstN), .armIn(armIn), .stopLimit(stopLimit),
    .lineA(lineA), .lineB(lineB), .rdEn(rdEn), .rdData(rdData),
    .fifoEmpty(fifoEmpty), .fifoOverflow(fifoOverflow),
    .runBusy(runBusy), .runDone(runDone)
  );

  always #2.5 clk = ~clk;

  int  cyc = 0;
  int  nChecks = 0;
  int  nFails = 0;
  bit  finished = 1'b0;
  int  startCyc;
  bit  lowIsA;
  int  expQ[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic stepN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doArm(input int lim);
    @(negedge clk);
    armIn = 1'b1;
    stopLimit = LIMIT_W'(lim);
    @(negedge clk);
    armIn = 1'b0;
    expQ.delete();
  endtask

  task automatic startRun();
    @(negedge clk);
    lineA = 1'b0;
    lineB = 1'b1;
    lowIsA = 1'b1;
    startCyc = cyc;
  endtask

  // complementary toggle: the high line falls, the low line rises
  task automatic capture(input int gap);
    stepN(gap);
    if (lowIsA) begin lineA = 1'b1; lineB = 1'b0; end
    else        begin lineA = 1'b0; lineB = 1'b1; end
    lowIsA = !lowIsA;
    if (expQ.size() < DEPTH) expQ.push_back(cyc - startCyc);
  endtask

  // R6: both low briefly, then the same line rises again
  task automatic dip(input int len);
    stepN(1);
    if (lowIsA) lineB = 1'b0; else lineA = 1'b0;
    stepN(len);
    if (lowIsA) lineB = 1'b1; else lineA = 1'b1;
  endtask

  task automatic stopRun(input int lim);
    @(negedge clk);
    lineA = 1'b0;
    lineB = 1'b0;
    stepN(lim);
    check(runBusy == 1'b1, "R7 busy before limit", runBusy, 1);
    stepN(8);
    check(runDone == 1'b1, "R7 done after limit", runDone, 1);
    check(runBusy == 1'b0, "R7 busy after stop", runBusy, 0);
    lineA = 1'b1;
    lineB = 1'b1;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < expQ.size(); i++) begin
      check(fifoEmpty == 1'b0, {tag, " not empty"}, fifoEmpty, 0);
      check(rdData == CNT_W'(expQ[i]), (i == 0) ? {tag, " R4 first stamp"} : {tag, " R5 stamp"},
            rdData, expQ[i]);
      rdEn = 1'b1;
      @(negedge clk);
      rdEn = 1'b0;
    end
    check(fifoEmpty == 1'b1, {tag, " R11 empty after drain"}, fifoEmpty, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int unsigned seedVal;
    int lim;
    seedVal = $urandom(32'd4711);
    stepN(3);
    // R1
    check(fifoEmpty == 1'b1, "R1 empty", fifoEmpty, 1);
    check(runBusy == 1'b0, "R1 busy", runBusy, 0);
    check(runDone == 1'b0, "R1 done", runDone, 0);
    check(fifoOverflow == 1'b0, "R1 overflow", fifoOverflow, 0);
    rstN = 1'b1;
    stepN(2);

    // directed run with a dip
    lim = 6;
    doArm(lim);
    check(runBusy == 1'b1, "R2 busy after arm", runBusy, 1);
    stepN(5);
    check(fifoEmpty == 1'b1, "R2 nothing while armed", fifoEmpty, 1);
    startRun();
    stepN(6);
    check(fifoEmpty == 1'b1, "R3 start writes nothing", fifoEmpty, 1);
    capture(3);
    capture(17);
    dip(2);
    stepN(5);
    check(runBusy == 1'b1, "R6 dip keeps run", runBusy, 1);
    capture(4);
    capture(29);
    capture(1 + 10);
    stopRun(lim);
    // R8: activity after done is ignored
    stepN(3);
    lineA = 1'b0; stepN(4); lineA = 1'b1; lineB = 1'b0; stepN(4); lineB = 1'b1;
    stepN(4);
    check(runDone == 1'b1, "R8 still done", runDone, 1);
    drain("R8 run1");
    // R11: read on empty
    rdEn = 1'b1; stepN(2); rdEn = 1'b0;
    check(fifoEmpty == 1'b1, "R11 empty read", fifoEmpty, 1);

    // overflow run
    doArm(0);
    startRun();
    for (int i = 0; i < DEPTH + 3; i++) capture(3 + int'($urandom_range(0, 9)));
    stepN(4);
    check(fifoOverflow == 1'b1, "R9 overflow set", fifoOverflow, 1);
    stopRun(0);
    check(fifoOverflow == 1'b1, "R10 overflow held after stop", fifoOverflow, 1);
    drain("R9 full");
    doArm(5);
    check(fifoOverflow == 1'b0, "R10 arm clears overflow", fifoOverflow, 0);
    check(runDone == 1'b0, "R2 arm clears done", runDone, 0);
    stepN(2);

    // random runs
    for (int r = 0; r < 6; r++) begin
      int nCap;
      lim = int'($urandom_range(0, 15));
      nCap = int'($urandom_range(1, DEPTH));
      doArm(lim);
      check(fifoEmpty == 1'b1, "R2 empty after arm", fifoEmpty, 1);
      stepN(int'($urandom_range(1, 6)));
      startRun();
      for (int k = 0; k < nCap; k++) begin
        if (lim > 2 && $urandom_range(0, 3) == 0) dip(int'($urandom_range(1, lim - 2)));
        capture(2 + int'($urandom_range(0, 40)));
      end
      stepN(4);
      check(fifoOverflow == 1'b0, "R9 no overflow below depth", fifoOverflow, 0);
      stopRun(lim);
      drain("R5 random");
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule